// File: doc/BRIEF.md
# Transmit VLAN Tag Inserter

This block sits in a transmit datapath between the frame source and the MAC. It accepts a byte-wide stream of frame bytes under a valid/ready handshake, with an end-of-frame marker on the final byte. With each frame comes a small set of per-frame controls: a request to tag the frame, a request to append a frame check sequence, and the 16-bit tag value. Two configuration inputs are shared by all frames: a global enable for tagging and the 16-bit tag protocol identifier.

When tagging is requested and globally enabled, the block stalls its input after the twelfth frame byte, which ends the two MAC addresses. It then emits four inserted bytes: the protocol identifier and then the tag, each most significant byte first. A tagged frame always ends with a CRC-32 check sequence. An untagged frame gets one only when its own request asks for it. The check sequence covers every byte that leaves the block, inserted bytes included.

Data bytes pass through with no added latency, so the output stream presents a frame without gaps except where the input has none to offer. The per-frame controls and the configuration are taken on the first byte of a frame and then frozen until the frame's last output byte has been accepted.

Top module: `txtag_inserter`

## Requirements
- R1: With tagging inactive and no check sequence requested, every input byte appears unchanged and in order at the output, and the output end marker sits on the final data byte.
- R2: With the check-sequence request set and tagging inactive, four bytes follow the data. They are the bitwise inverse of a CRC-32 over the frame (reflected polynomial 0xEDB88320, register preset to all ones), sent least significant byte first. The end marker is on the fourth of them.
- R3: With tagging active, four bytes follow the twelfth data byte: the protocol identifier from `cfg_tpid` high byte then low byte, then `in_tag` high byte then low byte. The remaining data follows them.
- R4: A tagged frame always carries the check sequence, whatever the per-frame check-sequence request says. It is computed over all output bytes including the four inserted ones.
- R5: When `cfg_tag_enable` is low, the per-frame tag request has no effect. The frame leaves untagged and gets a check sequence only if requested.
- R6: The per-frame controls and the configuration inputs are sampled on the first byte of a frame. Changes to them on later bytes of the same frame have no effect on that frame.
- R7: While an inserted tag byte or check-sequence byte is on the output, `in_ready` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value in the next cycle. No byte is lost or repeated under any pattern of backpressure.
- R9: A tag-requested frame shorter than twelve bytes gets no inserted bytes but still gets the check sequence. A tag-requested frame of exactly twelve bytes gets the four inserted bytes after its last data byte and then the check sequence.
- R10: After reset, with no input offered, `out_valid` is low and `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_tag_enable | input | 1 | Global permission for tag insertion |
| cfg_tpid | input | 16 | Tag protocol identifier placed before the tag |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of the input frame |
| in_tag_req | input | 1 | Per-frame request to insert a tag |
| in_fcs_req | input | 1 | Per-frame request to append the check sequence |
| in_tag | input | 16 | Per-frame tag value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Marks the final byte of the output frame |

## Verification
Every cycle, the assertions check several properties. The frozen per-frame context must not move inside a frame. Inserted and check-sequence bytes must hold steady under backpressure. A finished tag insertion on a frame whose data has ended must lead into the check sequence. The end marker must land on the last check-sequence byte whenever one is due. The CRC register must be preset again after each frame. Only the bench's scenarios can show byte values: the correct protocol identifier and tag in the right place, the CRC value itself, and the suppression of the tag request when the global enable is low or when the request changes after the first byte. The short-frame and exact-twelve-byte boundaries are also covered only by scenarios.

// File: rtl/txtag_pkg.sv
package txtag_pkg;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_TAG  = 2'd1,
    PH_FCS  = 2'd2
  } phase_e;

  typedef struct packed {
    logic        tag_on;
    logic        fcs_on;
    logic [15:0] tpid;
    logic [15:0] tag;
  } frame_ctx_t;

  // One byte of a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] cur,
                                           input logic [7:0]  b,
                                           input logic [31:0] poly);
    logic [31:0] r;
    r = cur ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txtag_ctx.sv
module txtag_ctx
  import txtag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_tag_enable,
  input  logic [15:0] cfg_tpid,
  input  logic        in_tag_req,
  input  logic        in_fcs_req,
  input  logic [15:0] in_tag,
  input  logic        out_hs,
  input  logic        out_fin,
  output frame_ctx_t  ctx
);

  logic       in_frame_q, in_frame_n;
  frame_ctx_t held_q, held_n, live;
  logic       held_en;

  always_comb begin
    live.tag_on = cfg_tag_enable & in_tag_req;
    live.fcs_on = in_fcs_req | (cfg_tag_enable & in_tag_req);
    live.tpid   = cfg_tpid;
    live.tag    = in_tag;
  end

  // Track the live inputs while idle; freeze once the first byte has gone.
  assign held_en = ~in_frame_q;

  always_comb begin
    in_frame_n = in_frame_q;
    if (out_fin)     in_frame_n = 1'b0;
    else if (out_hs) in_frame_n = 1'b1;
    held_n = held_en ? live : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      held_q     <= '0;
    end else begin
      in_frame_q <= in_frame_n;
      held_q     <= held_n;
    end
  end

  assign ctx = in_frame_q ? held_q : live;

  // R6
  ctx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame_q && $past(in_frame_q)) |-> (ctx == $past(ctx)));

endmodule

// File: rtl/txtag_crc.sv
module txtag_crc
  import txtag_pkg::*;
#(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic        clr,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  logic [31:0] crc_n;

  always_comb begin
    crc_n = crc_q;
    if (clr)      crc_n = '1;
    else if (upd) crc_n = crc_byte(crc_q, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_n;
  end

  // R4
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/txtag_seq.sv
module txtag_seq
  import txtag_pkg::*;
#(
  parameter int TAG_AFTER = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  frame_ctx_t  ctx,
  input  logic [31:0] crc_q,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        out_hs,
  output logic        out_fin,
  output logic        crc_upd
);

  localparam int IDX_W = $clog2(TAG_AFTER + 1);
  localparam logic [IDX_W-1:0] IDX_HIT = IDX_W'(TAG_AFTER - 1);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(TAG_AFTER);

  phase_e           phase_q, phase_n;
  logic [1:0]       sub_q, sub_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             done_q, done_n;
  logic [31:0]      fcs_word, tag_word;

  assign fcs_word = ~crc_q;
  assign tag_word = {ctx.tpid, ctx.tag};

  always_comb begin
    phase_n   = phase_q;
    sub_n     = sub_q;
    idx_n     = idx_q;
    done_n    = done_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    case (phase_q)
      PH_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last & ~ctx.fcs_on;
        if (in_valid && out_ready) begin
          if (in_last)               idx_n = '0;
          else if (idx_q != IDX_SAT) idx_n = idx_q + 1'b1;
          if (ctx.tag_on && idx_q == IDX_HIT) begin
            phase_n = PH_TAG;
            sub_n   = '0;
            done_n  = in_last;
          end else if (in_last && ctx.fcs_on) begin
            phase_n = PH_FCS;
            sub_n   = '0;
          end
        end
      end
      PH_TAG: begin
        out_valid = 1'b1;
        out_data  = tag_word[{~sub_q, 3'b000} +: 8];
        if (out_ready) begin
          sub_n = sub_q + 1'b1;
          if (sub_q == 2'd3) phase_n = done_q ? PH_FCS : PH_DATA;
        end
      end
      PH_FCS: begin
        out_valid = 1'b1;
        out_data  = fcs_word[{sub_q, 3'b000} +: 8];
        out_last  = (sub_q == 2'd3);
        if (out_ready) begin
          sub_n = sub_q + 1'b1;
          if (sub_q == 2'd3) begin
            phase_n = PH_DATA;
            done_n  = 1'b0;
          end
        end
      end
      default: phase_n = PH_DATA;
    endcase
  end

  assign out_hs  = out_valid & out_ready;
  assign out_fin = out_hs & out_last;
  assign crc_upd = out_hs & (phase_q != PH_FCS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      sub_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      sub_q   <= sub_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  // R8
  ins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && phase_q != PH_DATA) |=> (out_valid && $stable(out_data)));

  // R4
  tag_to_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && phase_q == PH_TAG && sub_q == 2'd3 && done_q) |=> (phase_q == PH_FCS));

  // R2
  last_on_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && ctx.fcs_on) |-> (phase_q == PH_FCS && sub_q == 2'd3));

  // R3
  tag_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAG) |-> (idx_q == IDX_SAT || done_q));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !$past(in_ready)) |-> ($past(out_hs) || !$past(out_valid) || $past(phase_q == PH_DATA) || phase_q == PH_DATA));

endmodule

// File: rtl/txtag_inserter.sv
module txtag_inserter
  import txtag_pkg::*;
#(
  parameter int          TAG_AFTER = 12,
  parameter logic [31:0] CRC_POLY  = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_tag_enable,
  input  logic [15:0] cfg_tpid,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_tag_req,
  input  logic        in_fcs_req,
  input  logic [15:0] in_tag,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);

  frame_ctx_t  ctx;
  logic [31:0] crc_q;
  logic        out_hs, out_fin, crc_upd;

  txtag_ctx u_ctx (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_tag_enable (cfg_tag_enable),
    .cfg_tpid       (cfg_tpid),
    .in_tag_req     (in_tag_req),
    .in_fcs_req     (in_fcs_req),
    .in_tag         (in_tag),
    .out_hs         (out_hs),
    .out_fin        (out_fin),
    .ctx            (ctx)
  );

  txtag_crc #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (crc_upd),
    .clr   (out_fin),
    .din   (out_data),
    .crc_q (crc_q)
  );

  txtag_seq #(.TAG_AFTER(TAG_AFTER)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx       (ctx),
    .crc_q     (crc_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_hs    (out_hs),
    .out_fin   (out_fin),
    .crc_upd   (crc_upd)
  );

endmodule

// File: tb/txtag_inserter_test.sv
module txtag_inserter_test;

  localparam int CLK_P = 10;

  typedef struct {
    logic [7:0] d;
    logic       l;
    logic       ins;
    int         req;
  } exp_t;

  logic        clk, rst_n;
  logic        cfg_tag_enable;
  logic [15:0] cfg_tpid;
  logic        in_valid, in_ready, in_last, in_tag_req, in_fcs_req;
  logic [7:0]  in_data;
  logic [15:0] in_tag;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;

  int   n_chk, n_fail;
  bit   bp_on, finished;
  exp_t sb[$];

  txtag_inserter uut (
    .clk(clk), .rst_n(rst_n), .cfg_tag_enable(cfg_tag_enable), .cfg_tpid(cfg_tpid),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_tag_req(in_tag_req), .in_fcs_req(in_fcs_req), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h exp %h", req, what, got, exp);
    end
  endtask

  // Backpressure pattern
  logic [7:0] lf;
  always @(negedge clk) begin
    if (!rst_n) lf = 8'h5A;
    else        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready = bp_on ? (lf[0] | lf[2]) : 1'b1;
  end

  // Monitor / scoreboard
  bit         prev_stall;
  logic [7:0] prev_data;
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      if (prev_stall) begin
        // R8 hold under backpressure
        check(out_valid && out_data == prev_data, 8, "hold", {23'd0, out_valid, out_data}, {24'd1, prev_data});
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, 1, "unexpected byte", {24'd0, out_data}, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.d && out_last == e.l, e.req, "byte",
                {23'd0, out_last, out_data}, {23'd0, e.l, e.d});
          // R7 input stalled on inserted bytes
          if (e.ins) check(!in_ready, 7, "in_ready on inserted", {31'd0, in_ready}, 32'd0);
        end
      end
    end
  end

  task automatic send_pkt(input int req, input int len, input bit vl, input bit fc,
                          input logic [15:0] tg, input bit gm, input logic [15:0] tp,
                          input bit scr, input int seed);
    exp_t        loc[$];
    logic [31:0] c;
    logic [7:0]  b;
    logic [31:0] tw;
    bit          ton, fon;
    ton = vl && gm;
    fon = fc || ton;
    c   = 32'hFFFF_FFFF;
    tw  = {tp, tg};
    for (int i = 0; i < len; i++) begin
      b = 8'(seed * 7 + i * 13 + 1);
      loc.push_back('{b, 1'b0, 1'b0, req});
      c = ref_crc(c, b);
      if (ton && i == 11) begin
        for (int k = 3; k >= 0; k--) begin
          b = tw[k*8 +: 8];
          loc.push_back('{b, 1'b0, 1'b1, req});
          c = ref_crc(c, b);
        end
      end
    end
    if (fon) begin
      for (int k = 0; k < 4; k++) loc.push_back('{8'(~c >> (8*k)), 1'b0, 1'b1, req});
    end
    loc[loc.size()-1].l = 1'b1;
    foreach (loc[j]) sb.push_back(loc[j]);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed * 7 + i * 13 + 1);
      in_last  = (i == len - 1);
      if (i == 0 || !scr) begin
        in_tag_req = vl; in_fcs_req = fc; in_tag = tg; cfg_tag_enable = gm; cfg_tpid = tp;
      end else begin
        in_tag_req = ~vl; in_fcs_req = ~fc; in_tag = ~tg; cfg_tag_enable = ~gm; cfg_tpid = ~tp;
      end
      #(CLK_P/4);
      while (!in_ready) begin
        @(negedge clk);
        #(CLK_P/4);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    int w;
    w = 0;
    while (sb.size() != 0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    // all expected bytes seen
    check(sb.size() == 0, 1, "drain", sb.size(), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung exp done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; bp_on = 1'b0; finished = 1'b0; prev_stall = 1'b0; prev_data = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    in_tag_req = 1'b0; in_fcs_req = 1'b0; in_tag = '0;
    cfg_tag_enable = 1'b0; cfg_tpid = 16'h8100;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_P/4);
    // R10 reset state
    check(!out_valid, 10, "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == out_ready, 10, "in_ready after reset", {31'd0, in_ready}, {31'd0, out_ready});

    // R1 plain pass-through
    send_pkt(1, 20, 1'b0, 1'b0, 16'h0123, 1'b1, 16'h8100, 1'b0, 3);
    // R2 check sequence only
    send_pkt(2, 16, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h8100, 1'b0, 5);
    // R3 R4 tagged, FCS request low but forced
    send_pkt(3, 30, 1'b1, 1'b0, 16'hA5C3, 1'b1, 16'h8100, 1'b0, 9);
    // R4 tagged with FCS request high, other tpid
    send_pkt(4, 25, 1'b1, 1'b1, 16'h0FF1, 1'b1, 16'h88A8, 1'b0, 11);
    // R5 tag request without global enable
    send_pkt(5, 18, 1'b1, 1'b0, 16'hBEEF, 1'b0, 16'h8100, 1'b0, 13);
    send_pkt(5, 18, 1'b1, 1'b1, 16'hBEEF, 1'b0, 16'h8100, 1'b0, 14);
    // R6 controls flip after first byte
    send_pkt(6, 22, 1'b0, 1'b0, 16'h1234, 1'b0, 16'h8100, 1'b1, 17);
    send_pkt(6, 22, 1'b1, 1'b0, 16'h5678, 1'b1, 16'h9100, 1'b1, 19);
    // R9 short and boundary frames
    send_pkt(9, 8,  1'b1, 1'b0, 16'h4321, 1'b1, 16'h8100, 1'b0, 21);
    send_pkt(9, 12, 1'b1, 1'b0, 16'h4321, 1'b1, 16'h8100, 1'b0, 23);
    send_pkt(9, 13, 1'b1, 1'b0, 16'h7777, 1'b1, 16'h8100, 1'b0, 25);
    send_pkt(9, 1,  1'b0, 1'b1, 16'h0000, 1'b0, 16'h8100, 1'b0, 27);
    drain();
    // R8 the same kinds of frames under backpressure
    bp_on = 1'b1;
    send_pkt(8, 20, 1'b1, 1'b0, 16'hC001, 1'b1, 16'h8100, 1'b0, 31);
    send_pkt(8, 14, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h8100, 1'b1, 33);
    send_pkt(8, 12, 1'b1, 1'b1, 16'h2468, 1'b1, 16'h88A8, 1'b1, 35);
    send_pkt(8, 9,  1'b0, 1'b0, 16'h0000, 1'b0, 16'h8100, 1'b0, 37);
    drain();
    bp_on = 1'b0;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule